// File: doc/BRIEF.md
# Running-disparity DC-balance encoder

This block is the transmit-side line coder for a three-lane parallel-to-serial link that must stay DC-balanced so the link can be AC-coupled. Once per frame it takes a 21-bit parallel word, cuts it into three 7-bit groups and sends each group on its own serial lane as a 9-bit frame. The frame starts with a pair of complementary flag bits that tell the receiver whether the group that follows was inverted, then carries the seven group bits. A fourth lane carries a frame-rate clock pattern whose high time alternates between four and five bit slots of nine, so that it is balanced over two frames.

Each data lane keeps a running ones-minus-zeros sum of every bit it has sent, flag bits included. At each frame boundary a group is sent inverted when the running sum is nonzero and the group's own disparity has the same sign, which pushes the sum back towards zero and keeps it within plus or minus 10. The serial outputs advance by one bit only on cycles where the bit-rate enable is high, so the block can run from a fast system clock with any bit rate below it.

A small sequencer drives everything. It has three states: SEQ_IDLE after reset, SEQ_FLAG while the two flag bits are on the line, and SEQ_DATA while the seven group bits are on the line. The transitions are: SEQ_IDLE to SEQ_FLAG on the first enable (first word loaded); SEQ_FLAG to itself after the first flag bit; SEQ_FLAG to SEQ_DATA after the second flag bit; SEQ_DATA to itself on each of the first six group bits; SEQ_DATA to SEQ_FLAG after the last group bit, loading the next word.

Top module: `dcb_encoder`

## Requirements
- R1: After reset all data lanes and the clock lane are 0, the fault output is 0 and nothing is loaded until the first cycle with bit_en high.
- R2: word_in is captured exactly on the cycles where word_take is high, which are the bit_en cycles in the idle state or on the last bit slot of a frame; lane k carries word bits 7k+6 down to 7k.
- R3: Each frame is 9 bits sent in order: the inversion flag (1 means inverted), its complement, then the seven group bits from the highest to the lowest index.
- R4: A group is inverted exactly when the lane's running sum at the frame boundary is nonzero and the group's disparity (ones minus zeros) has the same sign; all-ones words therefore alternate plain and inverted frames starting with plain.
- R5: The running sum counts every transmitted bit of the lane, flags included, as +1 for a 1 and -1 for a 0, and restarts from 0 at reset, so the first frame after any reset is never inverted.
- R6: On a cycle with bit_en low no output changes.
- R7: The clock lane is high for the first 4 slots of the first frame after reset and low for the other 5, high for the first 5 slots of the next frame and low for the last 4, and keeps alternating.
- R8: Every data lane's running sum stays within -10 to +10 after every bit, inside frames as well as at their boundaries.
- R9: dsv_fault rises once any lane's running sum leaves -10 to +10, stays high until reset, and is low while all sums have stayed inside that range.
- R10: Each lane's inversion decision depends only on its own group and its own running sum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | Advances all serial lanes by one bit |
| word_in | input | 21 | Parallel word, three 7-bit groups |
| word_take | output | 1 | High on the cycle word_in is captured |
| lane_out | output | 3 | Serial data bit of each lane |
| clk_lane_out | output | 1 | Serial bit of the clock lane |
| dsv_fault | output | 1 | Sticky running-sum range fault |

## Verification
The checker keeps its own running sum of each lane from the serial outputs and checks on every cycle that it stays within plus or minus 10, that the fault flag stays low while those sums have stayed in range and is sticky, that outputs hold without an enable, that the two flag bits are complementary and that the clock lane rises at slot 0 and is low on the last slot. The inversion choice for each particular word, the bit order inside a frame, the mapping of word bits to lanes, the alternating clock duty and the restart of the sums after a mid-stream reset can only be shown by the bench's scenarios, which compare every serial bit against a frame model built from the requirements.

// File: rtl/dcb_pkg.sv
package dcb_pkg;

    // Frame sequencer states: idle after reset, flag pair, group bits.
    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_FLAG = 2'd1,
        SEQ_DATA = 2'd2
    } seq_state_t;

endpackage

// File: rtl/dcb_seq.sv
module dcb_seq
    import dcb_pkg::*;
#(
    parameter int unsigned FRAME_W  = 9,
    parameter int unsigned FLAG_W   = 2,
    parameter int unsigned HI_SHORT = 4,
    parameter int unsigned SLOT_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_en,
    output logic              load,
    output logic              tally,
    output logic              sending,
    output logic              clk_lane,
    output logic [SLOT_W-1:0] slot
);

    localparam int unsigned HI_LONG = FRAME_W - HI_SHORT;
    localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(FRAME_W - 1);
    localparam logic [SLOT_W-1:0] FLAG_LAST = SLOT_W'(FLAG_W - 1);
    localparam logic [SLOT_W-1:0] HI_S = SLOT_W'(HI_SHORT);
    localparam logic [SLOT_W-1:0] HI_L = SLOT_W'(HI_LONG);

    seq_state_t        state_q, state_d;
    logic [SLOT_W-1:0] slot_q, slot_d;
    logic              long_q, long_d;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEQ_IDLE;
            slot_q  <= '0;
            long_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            slot_q  <= slot_d;
            long_q  <= long_d;
        end
    end

    // Next state and outputs
    always_comb begin
        state_d = state_q;
        slot_d  = slot_q;
        long_d  = long_q;
        load    = 1'b0;
        unique case (state_q)
            SEQ_IDLE: begin
                if (bit_en) begin
                    load    = 1'b1;
                    slot_d  = '0;
                    long_d  = 1'b0;
                    state_d = SEQ_FLAG;
                end
            end
            SEQ_FLAG: begin
                if (bit_en) begin
                    slot_d = slot_q + 1'b1;
                    if (slot_q == FLAG_LAST) begin
                        state_d = SEQ_DATA;
                    end
                end
            end
            SEQ_DATA: begin
                if (bit_en) begin
                    if (slot_q == SLOT_LAST) begin
                        load    = 1'b1;
                        slot_d  = '0;
                        long_d  = ~long_q;
                        state_d = SEQ_FLAG;
                    end else begin
                        slot_d = slot_q + 1'b1;
                    end
                end
            end
            default: begin
                state_d = SEQ_IDLE;
            end
        endcase
    end

    assign sending  = (state_q != SEQ_IDLE);
    assign tally    = bit_en && sending;
    assign clk_lane = sending && (slot_q < (long_q ? HI_L : HI_S));
    assign slot     = slot_q;

endmodule

// File: rtl/dcb_lane_coder.sv
module dcb_lane_coder #(
    parameter int unsigned GRP_W     = 7,
    parameter int unsigned SUM_W     = 6,
    parameter int unsigned DSV_LIMIT = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             tally,
    input  logic [GRP_W-1:0] group,
    output logic             ser_bit,
    output logic             range_fault
);

    localparam int unsigned FRAME_W = GRP_W + 2;
    localparam logic signed [SUM_W-1:0] ONE     = SUM_W'(1);
    localparam logic signed [SUM_W-1:0] GRP_W_S = SUM_W'(GRP_W);
    localparam logic signed [SUM_W-1:0] LIM_P   = SUM_W'(DSV_LIMIT);
    localparam logic signed [SUM_W-1:0] LIM_N   = -LIM_P;

    logic [FRAME_W-1:0]      sh_q;
    logic signed [SUM_W-1:0] sum_q;
    logic signed [SUM_W-1:0] step;
    logic signed [SUM_W-1:0] sum_cur;
    logic signed [SUM_W-1:0] ones;
    logic signed [SUM_W-1:0] grp_disp;
    logic                    invert;
    logic                    fault_q;

    // Disparity of the incoming group
    always_comb begin
        ones = '0;
        for (int i = 0; i < int'(GRP_W); i++) begin
            ones = ones + {{(SUM_W-1){1'b0}}, group[i]};
        end
        grp_disp = (ones <<< 1) - GRP_W_S;
    end

    // Sum including the bit that is on the line this cycle
    assign step    = !tally ? '0 : (sh_q[FRAME_W-1] ? ONE : -ONE);
    assign sum_cur = sum_q + step;

    assign invert = (sum_cur != '0) && (grp_disp != '0) &&
                    (sum_cur[SUM_W-1] == grp_disp[SUM_W-1]);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q    <= '0;
            sum_q   <= '0;
            fault_q <= 1'b0;
        end else begin
            if (load) begin
                sh_q <= {invert, ~invert, (invert ? ~group : group)};
            end else if (tally) begin
                sh_q <= {sh_q[FRAME_W-2:0], 1'b0};
            end
            if (tally) begin
                sum_q <= sum_cur;
                if ((sum_cur > LIM_P) || (sum_cur < LIM_N)) begin
                    fault_q <= 1'b1;
                end
            end
        end
    end

    assign ser_bit     = sh_q[FRAME_W-1];
    assign range_fault = fault_q;

endmodule

// File: rtl/dcb_encoder.sv
module dcb_encoder #(
    parameter int unsigned LANES     = 3,
    parameter int unsigned GRP_W     = 7,
    parameter int unsigned SUM_W     = 6,
    parameter int unsigned DSV_LIMIT = 10
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   bit_en,
    input  logic [LANES*GRP_W-1:0] word_in,
    output logic                   word_take,
    output logic [LANES-1:0]       lane_out,
    output logic                   clk_lane_out,
    output logic                   dsv_fault
);

    localparam int unsigned FRAME_W  = GRP_W + 2;
    localparam int unsigned HI_SHORT = FRAME_W / 2;
    localparam int unsigned SLOT_W   = $clog2(FRAME_W);

    logic              seq_load;
    logic              seq_tally;
    logic              seq_active;
    logic [SLOT_W-1:0] seq_slot;
    logic [LANES-1:0]  lane_fault;

    dcb_seq #(
        .FRAME_W  (FRAME_W),
        .FLAG_W   (2),
        .HI_SHORT (HI_SHORT),
        .SLOT_W   (SLOT_W)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_en   (bit_en),
        .load     (seq_load),
        .tally    (seq_tally),
        .sending  (seq_active),
        .clk_lane (clk_lane_out),
        .slot     (seq_slot)
    );

    for (genvar k = 0; k < int'(LANES); k++) begin : g_lane
        dcb_lane_coder #(
            .GRP_W     (GRP_W),
            .SUM_W     (SUM_W),
            .DSV_LIMIT (DSV_LIMIT)
        ) u_lane (
            .clk         (clk),
            .rst_n       (rst_n),
            .load        (seq_load),
            .tally       (seq_tally),
            .group       (word_in[k*GRP_W +: GRP_W]),
            .ser_bit     (lane_out[k]),
            .range_fault (lane_fault[k])
        );
    end

    assign word_take = seq_load;
    assign dsv_fault = |lane_fault;

endmodule

// File: rtl/dcb_encoder_chk.sv
module dcb_encoder_chk #(
    parameter int unsigned LANES     = 3,
    parameter int unsigned SUM_W     = 6,
    parameter int unsigned DSV_LIMIT = 10,
    parameter int unsigned FRAME_W   = 9,
    parameter int unsigned SLOT_W    = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bit_en,
    input logic              word_take,
    input logic              sending,
    input logic [SLOT_W-1:0] slot,
    input logic [LANES-1:0]  lane_out,
    input logic              clk_lane_out,
    input logic              dsv_fault
);

    localparam logic signed [SUM_W-1:0] ONE   = SUM_W'(1);
    localparam logic signed [SUM_W-1:0] LIM_P = SUM_W'(DSV_LIMIT);
    localparam logic signed [SUM_W-1:0] LIM_N = -LIM_P;
    localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(FRAME_W - 1);

    logic signed [SUM_W-1:0] ref_sum [LANES];
    logic                    in_range;
    logic                    ok_hist_q;
    logic                    all_ok;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < int'(LANES); k++) ref_sum[k] <= '0;
            ok_hist_q <= 1'b1;
        end else begin
            if (bit_en && sending) begin
                for (int k = 0; k < int'(LANES); k++) begin
                    ref_sum[k] <= lane_out[k] ? ref_sum[k] + ONE : ref_sum[k] - ONE;
                end
            end
            ok_hist_q <= all_ok;
        end
    end

    always_comb begin
        in_range = 1'b1;
        for (int k = 0; k < int'(LANES); k++) begin
            if ((ref_sum[k] > LIM_P) || (ref_sum[k] < LIM_N)) in_range = 1'b0;
        end
    end

    assign all_ok = ok_hist_q && in_range;

    // R8
    sum_bound_chk: assert property (@(posedge clk) disable iff (!rst_n) in_range);

    // R9
    fault_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n) all_ok |-> !dsv_fault);

    // R9
    fault_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n) dsv_fault |=> dsv_fault);

    // R6
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> ($stable(lane_out) && $stable(clk_lane_out)));

    // R3
    flag_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && sending && slot == '0) |=> (lane_out == ~$past(lane_out)));

    // R7
    clk_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sending && slot == '0) |-> clk_lane_out);

    // R7
    clk_tail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sending && slot == SLOT_LAST) |-> !clk_lane_out);

    // R2
    take_en_chk: assert property (@(posedge clk) disable iff (!rst_n) word_take |-> bit_en);

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sending |-> (lane_out == '0 && !clk_lane_out));

endmodule

bind dcb_encoder dcb_encoder_chk #(
    .LANES     (LANES),
    .SUM_W     (SUM_W),
    .DSV_LIMIT (DSV_LIMIT),
    .FRAME_W   (FRAME_W),
    .SLOT_W    (SLOT_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bit_en       (bit_en),
    .word_take    (word_take),
    .sending      (seq_active),
    .slot         (seq_slot),
    .lane_out     (lane_out),
    .clk_lane_out (clk_lane_out),
    .dsv_fault    (dsv_fault)
);

// File: tb/sim_dcb_encoder.sv
module sim_dcb_encoder;

    localparam int LN = 3;
    localparam int GW = 7;
    localparam int FW = 9;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            bit_en = 1'b0;
    logic [LN*GW-1:0] word_in = '0;
    logic            word_take;
    logic [LN-1:0]   lane_out;
    logic            clk_lane_out;
    logic            dsv_fault;

    int checks = 0;
    int fails = 0;
    int rs_m [LN];
    logic [FW-1:0] cur_f [LN];
    int frame_no = 0;

    always #2 clk = ~clk;

    dcb_encoder u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .bit_en       (bit_en),
        .word_in      (word_in),
        .word_take    (word_take),
        .lane_out     (lane_out),
        .clk_lane_out (clk_lane_out),
        .dsv_fault    (dsv_fault)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Model of one lane's frame from R3/R4/R5
    task automatic model_load(input logic [LN*GW-1:0] w);
        for (int k = 0; k < LN; k++) begin
            logic [GW-1:0] g;
            int ones;
            int d;
            bit inv;
            g = w[k*GW +: GW];
            ones = 0;
            for (int i = 0; i < GW; i++) ones += int'(g[i]);
            d = 2 * ones - GW;
            inv = (rs_m[k] != 0) && (d != 0) && ((rs_m[k] > 0) == (d > 0));
            cur_f[k] = {inv, ~inv, (inv ? ~g : g)};
            rs_m[k] += inv ? -d : d;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        bit_en = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        for (int k = 0; k < LN; k++) rs_m[k] = 0;
        frame_no = 0;
        @(negedge clk);
    endtask

    // Idle to first frame: R1, R2
    task automatic start(input logic [LN*GW-1:0] w);
        chk(lane_out === '0, "R1", "idle lanes", 32'(lane_out), 0);
        chk(clk_lane_out === 1'b0, "R1", "idle clock lane", 32'(clk_lane_out), 0);
        chk(dsv_fault === 1'b0, "R1", "fault after reset", 32'(dsv_fault), 0);
        #1;
        chk(word_take === 1'b0, "R1", "take without enable", 32'(word_take), 0);
        @(negedge clk);
        chk(lane_out === '0, "R1", "idle hold", 32'(lane_out), 0);
        word_in = w;
        bit_en = 1'b1;
        #1;
        chk(word_take === 1'b1, "R2", "take on first enable", 32'(word_take), 1);
        @(posedge clk);
        @(negedge clk);
        bit_en = 1'b0;
        model_load(w);
    endtask

    // Send the frame on the line, loading next_w at its end
    task automatic run_frame(input logic [LN*GW-1:0] next_w, input int gap, input string tag);
        for (int s = 0; s < FW; s++) begin
            logic [LN-1:0] expv;
            bit cexp;
            for (int k = 0; k < LN; k++) expv[k] = cur_f[k][FW-1-s];
            cexp = (s < ((frame_no % 2 == 1) ? 5 : 4));
            chk(lane_out === expv, tag, $sformatf("frame %0d slot %0d lanes", frame_no, s),
                32'(lane_out), 32'(expv));
            chk(clk_lane_out === cexp, "R7", $sformatf("frame %0d slot %0d clock", frame_no, s),
                32'(clk_lane_out), 32'(cexp));
            chk(dsv_fault === 1'b0, "R9", "fault low", 32'(dsv_fault), 0);
            for (int g = 0; g < gap; g++) begin
                @(negedge clk);
                chk(lane_out === expv && clk_lane_out === cexp, "R6", "hold without enable",
                    32'({clk_lane_out, lane_out}), 32'({cexp, expv}));
            end
            if (s == FW - 1) word_in = next_w;
            bit_en = 1'b1;
            #1;
            chk(word_take === (s == FW - 1), "R2", $sformatf("take at slot %0d", s),
                32'(word_take), 32'(s == FW - 1));
            @(posedge clk);
            @(negedge clk);
            bit_en = 1'b0;
            if (s == FW - 1) begin
                model_load(next_w);
                frame_no++;
            end
        end
    endtask

    // R4: all ones alternate plain and inverted
    task automatic t_all_ones();
        logic [LN*GW-1:0] w;
        w = '1;
        do_reset();
        start(w);
        for (int f = 0; f < 6; f++) begin
            if (f < 2) chk(cur_f[0][FW-1] === (f % 2 == 1), "R4", "ones flag model", 32'(cur_f[0][FW-1]), 32'(f % 2));
            run_frame(w, 0, "R4");
        end
    endtask

    // R4: all zeros
    task automatic t_all_zeros();
        do_reset();
        start('0);
        for (int f = 0; f < 5; f++) run_frame('0, 0, "R4");
    endtask

    // R10, R2: distinct pattern per lane
    task automatic t_lanes();
        logic [LN*GW-1:0] wa, wb;
        wa = {7'b0101010, 7'b0000000, 7'b1111111};
        wb = {7'b1110001, 7'b1011111, 7'b0000011};
        do_reset();
        start(wa);
        for (int f = 0; f < 6; f++) run_frame((f % 2 == 0) ? wb : wa, 0, "R10");
    endtask

    // R6: gaps between enables
    task automatic t_gaps();
        do_reset();
        start(21'h1F0F3C);
        for (int f = 0; f < 4; f++) run_frame(21'(32'h0A5C3 * (f + 3)), 2, "R6");
    endtask

    // R5: sums restart at reset; mid-stream reset
    task automatic t_sum_restart();
        do_reset();
        start('1);
        run_frame('1, 0, "R5");
        run_frame('1, 0, "R5");
        do_reset();
        start('1);
        chk(cur_f[0][FW-1] === 1'b0, "R5", "first frame after reset plain", 32'(cur_f[0][FW-1]), 0);
        run_frame('1, 0, "R5");
        run_frame('1, 0, "R5");
    endtask

    // R3, R8: random stream
    task automatic t_random();
        do_reset();
        start(21'($urandom));
        for (int f = 0; f < 150; f++) run_frame(21'($urandom), f % 3 == 0 ? 1 : 0, "R3");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog run did not finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        t_all_ones();
        t_all_zeros();
        t_lanes();
        t_gaps();
        t_sum_restart();
        t_random();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule